// File: doc/BRIEF.md
# Workstation Interrupt Control Register

This block is a 32-bit memory-mapped control register that drives the seven interrupt request levels of a 68k-style processor. Software writes it through a byte-lane-masked write port and reads it back through a read port. One bit is a master enable. Three bits request software interrupts at levels 1, 2 and 3. A further bit gates a periodic clock tick onto level 7. The master enable gates every level, so clearing it drops all of them in one write.

A built-in divider makes a one-cycle tick strobe every `TICK_DIV` clock cycles. The default is sized for a 100 Hz tick from the system clock. While the tick gate and the master enable are both set, each tick makes level 7 fall for exactly one cycle and then rise again. The interrupt encoder downstream therefore sees a fresh edge every period. A level-7 request from a memory-error source is merged into the same output, also under the master enable. Priority encoding and vector generation are left to the processor side.

Top module: `irqc_top`

## Requirements
- R1: After reset the stored register value is 0x00000000 and all seven request outputs are low.
- R2: A write with `wr_be[k]` set replaces bits 8k+7..8k of the stored value with the same bits of `wr_data`. A write with `wr_be[k]` clear leaves those bits unchanged.
- R3: When stored bit 24 (master enable) is 0, all seven request outputs are low, including level 7 while `mem_err_req` is high. A write that clears bit 24 drops every level in the cycle after the write edge.
- R4: With bit 24 set, stored bits 25, 26 and 27 drive the level 1, 2 and 3 requests (`irq_lvl[0]`, `irq_lvl[1]`, `irq_lvl[2]`). Each request stays high until a later write clears its bit or bit 24.
- R5: A write that leaves stored bit 31 (tick gate) at 0 while the master enable is set drops a pending tick request on level 7. No tick request returns while bit 31 stays 0.
- R6: While bits 31 and 24 are both set, each tick strobe makes level 7 go low for exactly one cycle and then high again. Successive low cycles are `TICK_DIV` cycles apart.
- R7: With bit 24 set, level 7 is high whenever `mem_err_req` is high, whatever the tick state.
- R8: Levels 4, 5 and 6 (`irq_lvl[3]` to `irq_lvl[5]`) are always low.
- R9: `rd_data` always equals the stored register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables, bit k covers data bits 8k+7..8k |
| rd_data | output | 32 | Current stored register value |
| mem_err_req | input | 1 | Level-7 request from the memory-error source |
| irq_lvl | output | 7 | Request lines; bit n-1 is level n |

## Verification
The hardest situation to reach is the one-cycle dip of level 7 at a tick. Its phase depends on a free-running divider that the ports do not expose. The bench enables the gate and waits for level 7 to rise. It then watches cycle by cycle for the first low sample, checks that the very next sample is high again, and measures the spacing to the following dip against `TICK_DIV`. The cancel path is reached by writing a value with the gate bit clear while a tick request is high. The bench then holds for two full periods to confirm that no request returns.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int LVL_CNT = 7;
   localparam int LANE_W  = 8;
endpackage

// File: rtl/irqc_tick_div.sv
module irqc_tick_div #(
   parameter int TICK_DIV = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   initial assert (TICK_DIV >= 2) else $error("TICK_DIV must be at least 2");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= (cnt_q == LAST);
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6: the tick strobe lasts one cycle
   a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R6: the divider count stays in range
   a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/irqc_lane_reg.sv
module irqc_lane_reg
   import irqc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W/LANE_W-1:0] wr_be,
   output logic [DATA_W-1:0] nxt_val,
   output logic [DATA_W-1:0] q
);
   localparam int LANES = DATA_W / LANE_W;

   initial assert (DATA_W % LANE_W == 0) else $error("DATA_W must be whole lanes");

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign nxt_val[k*LANE_W +: LANE_W] = wr_be[k] ? wr_data[k*LANE_W +: LANE_W]
                                                    : q[k*LANE_W +: LANE_W];
      always_ff @(posedge clk) begin
         if (!rst_n)     q[k*LANE_W +: LANE_W] <= '0;
         else if (wr_en) q[k*LANE_W +: LANE_W] <= nxt_val[k*LANE_W +: LANE_W];
      end
      // R2: a masked lane keeps its value
      a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_be[k]) |=> $stable(q[k*LANE_W +: LANE_W]));
      // R2: an enabled lane takes the written byte
      a_r2_lane_load: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_be[k]) |=> (q[k*LANE_W +: LANE_W] == $past(wr_data[k*LANE_W +: LANE_W])));
   end
endmodule

// File: rtl/irqc_lvl7.sv
module irqc_lvl7 (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic gate_on,
   input  logic kill,
   output logic req
);
   logic rearm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req     <= 1'b0;
         rearm_q <= 1'b0;
      end else if (kill) begin
         req     <= 1'b0;
         rearm_q <= 1'b0;
      end else if (rearm_q) begin
         req     <= 1'b1;
         rearm_q <= 1'b0;
      end else if (tick && gate_on) begin
         req     <= 1'b0;
         rearm_q <= 1'b1;
      end
   end

   // R5: a gate-clearing write drops the tick request
   a_r5_kill_drops: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!req && !rearm_q));
   // R6: a gated tick makes a one-cycle low
   a_r6_dip: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && gate_on && !kill && !rearm_q) |=> (!req && rearm_q));
   // R6: the request comes back after the dip
   a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm_q && !kill) |=> req);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int MASTER_BIT    = 24,
   parameter int SW_BASE_BIT   = 25,
   parameter int SW_CNT        = 3,
   parameter int TICK_GATE_BIT = 31,
   parameter int TICK_DIV      = 200000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [DATA_W/LANE_W-1:0] wr_be,
   output logic [DATA_W-1:0]        rd_data,
   input  logic                     mem_err_req,
   output logic [LVL_CNT-1:0]       irq_lvl
);
   initial begin
      assert (SW_CNT >= 1 && SW_CNT <= LVL_CNT - 1) else $error("SW_CNT out of range");
      assert (MASTER_BIT < DATA_W && TICK_GATE_BIT < DATA_W) else $error("bit out of range");
      assert (SW_BASE_BIT + SW_CNT <= DATA_W) else $error("software bits out of range");
   end

   logic [DATA_W-1:0] reg_q, reg_nxt;
   logic tick, t7_req, master, kill;

   irqc_lane_reg #(.DATA_W(DATA_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_be(wr_be), .nxt_val(reg_nxt), .q(reg_q));

   irqc_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   assign master = reg_q[MASTER_BIT];
   assign kill   = wr_en && !(reg_nxt[MASTER_BIT] && reg_nxt[TICK_GATE_BIT]);

   irqc_lvl7 u_l7 (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .gate_on(master && reg_q[TICK_GATE_BIT]), .kill(kill), .req(t7_req));

   for (genvar i = 0; i < LVL_CNT; i++) begin : g_lvl
      if (i < SW_CNT) begin : g_sw
         assign irq_lvl[i] = master && reg_q[SW_BASE_BIT + i];
      end else if (i == LVL_CNT - 1) begin : g_top
         assign irq_lvl[i] = master && (t7_req || mem_err_req);
      end else begin : g_none
         assign irq_lvl[i] = 1'b0;
      end
   end

   assign rd_data = reg_q;

   // R3: a write clearing the master bit drops every level
   a_r3_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[MASTER_BIT/LANE_W] && !wr_data[MASTER_BIT]) |=> (irq_lvl == '0));
   // R7: a memory-error request reaches level 7 under the master bit
   a_r7_mem_err: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_err_req && rd_data[MASTER_BIT]) |-> irq_lvl[LVL_CNT-1]);
   // R8: the unused middle levels stay low
   a_r8_mid_low: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lvl[LVL_CNT-2:SW_CNT] == '0);
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
   localparam int TD = 16;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] rd_data;
   logic        mem_err_req = 0;
   logic [6:0]  irq_lvl;
   int total = 0, bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irqc_top #(.TICK_DIV(TD)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_be(wr_be), .rd_data(rd_data), .mem_err_req(mem_err_req), .irq_lvl(irq_lvl));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] d, logic [3:0] be);
      @(negedge clk);
      wr_en = 1; wr_data = d; wr_be = be;
      @(negedge clk);
      wr_en = 0; wr_data = '0; wr_be = '0;
   endtask

   task automatic t_reset();
      chk("R1 reset value", rd_data, 32'h0);
      chk("R1 reset levels", {25'h0, irq_lvl}, 32'h0);
   endtask

   task automatic t_lanes();
      wr(32'hA5A5_5A5A, 4'b0101);
      chk("R2 lanes 0,2", rd_data, 32'h00A5_005A);
      chk("R9 readback", rd_data, 32'h00A5_005A);
      wr(32'h1234_5678, 4'b1010);
      chk("R2 lanes 1,3", rd_data, 32'h12A5_565A);
      wr(32'hFFFF_FFFF, 4'b0000);
      chk("R2 no lanes", rd_data, 32'h12A5_565A);
      wr(32'h0, 4'b1111);
      chk("R2 clear all", rd_data, 32'h0);
   endtask

   task automatic t_sw_levels();
      wr(32'h0E00_0000, 4'b1000);
      chk("R3 sw bits without master", {25'h0, irq_lvl}, 32'h0);
      wr(32'h0B00_0000, 4'b1000);
      chk("R4 levels 1 and 3", {25'h0, irq_lvl}, 32'h05);
      wr(32'h0000_00FF, 4'b0001);
      chk("R4 held across other-lane write", {25'h0, irq_lvl}, 32'h05);
      wr(32'h0500_0000, 4'b1000);
      chk("R4 level 2 only", {25'h0, irq_lvl}, 32'h02);
      chk("R8 mid levels low", {29'h0, irq_lvl[5:3]}, 32'h0);
      wr(32'h0400_0000, 4'b1000);
      chk("R3 master clear", {25'h0, irq_lvl}, 32'h0);
   endtask

   task automatic t_tick();
      int rise = -1, dip1 = -1, dip2 = -1;
      wr(32'h8100_0000, 4'b1000);
      for (int i = 0; i < TD + 4; i++) begin
         if (irq_lvl[6]) begin rise = i; break; end
         @(negedge clk);
      end
      chk("R6 first request", {31'h0, rise >= 0}, 32'h1);
      for (int i = 0; i < 3 * TD; i++) begin
         @(negedge clk);
         if (!irq_lvl[6]) begin
            if (dip1 < 0) dip1 = i; else begin dip2 = i; break; end
            @(negedge clk); i++;
            chk("R6 reasserted after one cycle", {31'h0, irq_lvl[6]}, 32'h1);
         end
      end
      chk("R6 dip spacing", dip2 - dip1, TD);
      chk("R8 mid levels low under tick", {29'h0, irq_lvl[5:3]}, 32'h0);
   endtask

   task automatic t_kill();
      int seen = 0;
      while (!irq_lvl[6]) @(negedge clk);
      wr(32'h0100_0000, 4'b1000);
      chk("R5 gate clear drops level 7", {31'h0, irq_lvl[6]}, 32'h0);
      for (int i = 0; i < 2 * TD; i++) begin
         @(negedge clk);
         if (irq_lvl[6]) seen++;
      end
      chk("R5 no tick request while gate clear", seen, 0);
   endtask

   task automatic t_memerr();
      mem_err_req = 1;
      @(negedge clk);
      chk("R7 mem error on level 7", {31'h0, irq_lvl[6]}, 32'h1);
      wr(32'h0000_0000, 4'b1000);
      chk("R3 master clear masks mem error", {25'h0, irq_lvl}, 32'h0);
      mem_err_req = 0;
      wr(32'h8F00_0000, 4'b1000);
      while (!irq_lvl[6]) @(negedge clk);
      wr(32'h0000_0000, 4'b1000);
      chk("R3 master clear drops all levels", {25'h0, irq_lvl}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_lanes();
      t_sw_levels();
      t_tick();
      t_kill();
      t_memerr();
      done = 1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule